// File: doc/BRIEF.md
# TDM Time-Slot and Bit Channel Mapper

This block takes a serial TDM stream and picks out the bits that belong to one logical channel. The stream is framed into 8-bit time slots. Each slot has an enable and an 8-bit mask, so a channel can be any mix of three kinds of capacity:

- whole slots at 64 kbit/s each, which together form a hyperchannel;
- single bit positions at 8 kbit/s each, which form a subchannel. For example, 7 bits of one slot give a 56 kbit/s channel;
- the whole stream, in the unchannelized mode.

The block produces a gated bit and a valid strobe, and the framing logic downstream consumes them.

Configuration arrives through a simple write port and goes into a pending copy. The pending copy becomes active on the first bit of the next frame. A frame is therefore always decoded with one consistent map. Bit position and slot position come from counters. The frame sync restarts these counters, and they advance only on bit-enable cycles.

Top module: `chan_slot_mapper`

## Requirements
- R1: After reset, valid_o and data_o are 0. All slots are disabled, all masks are zero and the channelized mode is selected, so no bit is valid until the block is configured.
- R2: A cycle with bit_en_i=1 and sync_i=1 carries bit 0 of slot 0. The bits that follow in the frame are numbered from that bit.
- R3: Each bit_en_i cycle advances the bit position. After bit 7 the next slot begins. After bit 7 of slot SLOTS-1 the position returns to slot 0 bit 0, even when no sync arrives.
- R4: In a slot that is enabled and has mask 0xFF, all 8 bits are valid.
- R5: In an enabled slot, the bit at position b (0 = the first bit of the slot) is valid only when mask bit 7-b is 1. Mask 0xFE gives 7 of 8 bits, which is 56 kbit/s.
- R6: A disabled slot produces no valid bit, whatever its mask holds.
- R7: In the unchannelized mode, every bit_en_i cycle produces a valid bit, whatever the slot and mask settings are.
- R8: valid_o and data_o change on the clock edge after the bit_en_i cycle they describe. data_o equals the data_i of that cycle when valid_o is 1, and is 0 otherwise.
- R9: A cycle with bit_en_i=0 gives valid_o=0 after the edge and leaves the bit and slot position unchanged.
- R10: A write changes only the pending map. The active map takes the pending values in the cycle that has bit_en_i=1 and sync_i=1, and that bit is already decoded with the new map.
- R11: The write encoding is as follows:
  - When cfg_addr_i MSB is 0, the low bits select a slot. cfg_data_i[8] is that slot's enable and cfg_data_i[7:0] is its mask.
  - When cfg_addr_i MSB is 1, cfg_data_i[0] selects the unchannelized mode (1) or the channelized mode (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | A line bit is present this cycle |
| sync_i | input | 1 | First bit of a frame (qualified by bit_en_i) |
| data_i | input | 1 | Serial line bit |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | $clog2(SLOTS)+1 | Slot index, or mode register when the MSB is set |
| cfg_data_i | input | 9 | Slot enable and mask, or mode bit |
| data_o | output | 1 | Channel bit, gated by valid_o |
| valid_o | output | 1 | data_o belongs to the channel |

## Verification
A wrong position counter shows up as a channel pattern that is shifted by whole bits or whole slots. This is visible at valid_o in the first frame after the error, and within at most 8 bit cycles for a bit offset. A corrupted active map, or a map that switches at the wrong moment, changes the strobe pattern of a whole frame. This is observed by comparing frames before and after writes made in the middle of a frame. An error in the mode bit sets or clears valid_o on every bit, and this is visible on the next bit_en_i cycle.

// File: rtl/cmap_pkg.sv
package cmap_pkg;
  localparam int unsigned BITS_PER_SLOT = 8;
  localparam int unsigned BIT_W = 3;

  typedef struct packed {
    logic       en;
    logic [7:0] mask;
  } slot_cfg_t;
endpackage

// File: rtl/cmap_pos_cnt.sv
module cmap_pos_cnt #(
  parameter int unsigned SLOTS  = 32,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bit_en_i,
  input  logic                     sync_i,
  output logic [SLOT_W-1:0]        slot_o,
  output logic [cmap_pkg::BIT_W-1:0] bit_o
);
  import cmap_pkg::*;

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BITS_PER_SLOT - 1);

  logic [SLOT_W-1:0] cnt_slot_q;
  logic [BIT_W-1:0]  cnt_bit_q;

  // sync forces the position of the current bit to slot 0 bit 0
  assign slot_o = (bit_en_i && sync_i) ? '0 : cnt_slot_q;
  assign bit_o  = (bit_en_i && sync_i) ? '0 : cnt_bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_slot_q <= '0;
      cnt_bit_q  <= '0;
    end else if (bit_en_i) begin
      if (bit_o == LAST_BIT) begin
        cnt_bit_q  <= '0;
        cnt_slot_q <= (slot_o == LAST_SLOT) ? '0 : slot_o + 1'b1;
      end else begin
        cnt_bit_q  <= bit_o + 1'b1;
        cnt_slot_q <= slot_o;
      end
    end
  end

  a_r2_sync_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && sync_i |=> cnt_slot_q == '0 && cnt_bit_q == BIT_W'(1));

  a_r3_frame_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && !sync_i && cnt_bit_q == LAST_BIT && cnt_slot_q == LAST_SLOT
    |=> cnt_slot_q == '0 && cnt_bit_q == '0);

  a_r9_hold_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(cnt_slot_q) && $stable(cnt_bit_q));
endmodule

// File: rtl/cmap_cfg_regs.sv
module cmap_cfg_regs #(
  parameter int unsigned SLOTS  = 32,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned AW     = SLOT_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [8:0]             wdata_i,
  input  logic                   apply_i,
  input  logic [SLOT_W-1:0]      slot_i,
  output cmap_pkg::slot_cfg_t    cfg_o,
  output logic                   unch_o
);
  import cmap_pkg::*;

  slot_cfg_t [SLOTS-1:0] shd_q, act_q;
  logic                  shd_unch_q, act_unch_q;
  logic                  mode_we;

  assign mode_we = we_i && addr_i[AW-1];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_q[g] <= '0;
      end else if (we_i && !addr_i[AW-1] && addr_i[SLOT_W-1:0] == SLOT_W'(g)) begin
        shd_q[g] <= slot_cfg_t'(wdata_i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_unch_q <= 1'b0;
      act_unch_q <= 1'b0;
      act_q      <= '0;
    end else begin
      if (mode_we) shd_unch_q <= wdata_i[0];
      if (apply_i) begin
        act_q      <= shd_q;
        act_unch_q <= shd_unch_q;
      end
    end
  end

  // the frame's first bit already sees the pending map
  assign cfg_o  = apply_i ? shd_q[slot_i] : act_q[slot_i];
  assign unch_o = apply_i ? shd_unch_q : act_unch_q;

  a_r10_active_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(act_q) && $stable(act_unch_q));

  a_r11_mode_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we |=> shd_unch_q == $past(wdata_i[0]));
endmodule

// File: rtl/cmap_bit_sel.sv
module cmap_bit_sel (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bit_en_i,
  input  logic                       data_i,
  input  cmap_pkg::slot_cfg_t        cfg_i,
  input  logic                       unch_i,
  input  logic [cmap_pkg::BIT_W-1:0] bit_i,
  output logic                       data_o,
  output logic                       valid_o
);
  import cmap_pkg::*;

  logic take;

  // mask bit 7 covers the first bit of the slot
  assign take = bit_en_i && (unch_i || (cfg_i.en && cfg_i.mask[BIT_W'(BITS_PER_SLOT - 1) - bit_i]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= 1'b0;
    end else begin
      valid_o <= take;
      data_o  <= take & data_i;
    end
  end

  a_r8_valid_needs_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bit_en_i));

  a_r8_data_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !data_o);

  a_r7_unch_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && unch_i |=> valid_o && data_o == $past(data_i));
endmodule

// File: rtl/chan_slot_mapper.sv
module chan_slot_mapper #(
  parameter int unsigned SLOTS  = 32,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned AW     = SLOT_W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_en_i,
  input  logic          sync_i,
  input  logic          data_i,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [8:0]    cfg_data_i,
  output logic          data_o,
  output logic          valid_o
);
  import cmap_pkg::*;

  logic [SLOT_W-1:0] cur_slot;
  logic [BIT_W-1:0]  cur_bit;
  slot_cfg_t         cur_cfg;
  logic              cur_unch;
  logic              apply;

  assign apply = bit_en_i && sync_i;

  cmap_pos_cnt #(.SLOTS(SLOTS)) u_pos (
    .clk_i, .rst_ni, .bit_en_i, .sync_i,
    .slot_o(cur_slot), .bit_o(cur_bit)
  );

  cmap_cfg_regs #(.SLOTS(SLOTS)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_data_i),
    .apply_i(apply), .slot_i(cur_slot),
    .cfg_o(cur_cfg), .unch_o(cur_unch)
  );

  cmap_bit_sel u_sel (
    .clk_i, .rst_ni, .bit_en_i, .data_i,
    .cfg_i(cur_cfg), .unch_i(cur_unch), .bit_i(cur_bit),
    .data_o, .valid_o
  );

  a_r1_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !valid_o && !data_o);
endmodule

// File: tb/sim_chan_slot_mapper.sv
module sim_chan_slot_mapper;
  localparam int SLOTS = 32;
  localparam int AW = $clog2(SLOTS) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 0, sync = 0, din = 0, cfg_we = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [8:0] cfg_data = '0;
  logic dout, valid;

  int n_checks = 0, n_errors = 0;
  logic [15:0] lf = 16'hACE1;

  logic       pend_en[SLOTS], act_en[SLOTS];
  logic [7:0] pend_mask[SLOTS], act_mask[SLOTS];
  logic       pend_unch = 0, act_unch = 0;

  always #2 clk = ~clk;

  chan_slot_mapper #(.SLOTS(SLOTS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .sync_i(sync), .data_i(din),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .data_o(dout), .valid_o(valid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [AW-1:0] a, input logic [8:0] d);
    @(negedge clk);
    bit_en = 0; sync = 0; cfg_we = 1; cfg_addr = a; cfg_data = d;
    @(posedge clk); #1;
    // R9: idle cycle gives no valid bit
    check(valid == 1'b0, "R9 idle valid", int'(valid), 0);
    @(negedge clk); cfg_we = 0;
    if (a[AW-1]) pend_unch = d[0];
    else begin pend_en[a[AW-2:0]] = d[8]; pend_mask[a[AW-2:0]] = d[7:0]; end
  endtask

  // one frame of SLOTS*8 bits; optional write in the middle
  task automatic run_frame(input bit use_sync, input int gap_at,
                           input logic [AW-1:0] ga, input logic [8:0] gd, input string tag);
    for (int i = 0; i < SLOTS * 8; i++) begin
      int s, b;
      logic ev, ed;
      if (i == gap_at) cfg_write(ga, gd);
      s = i / 8; b = i % 8;
      @(negedge clk);
      bit_en = 1; sync = use_sync && (i == 0); din = lf[0];
      if (sync) begin
        for (int k = 0; k < SLOTS; k++) begin act_en[k] = pend_en[k]; act_mask[k] = pend_mask[k]; end
        act_unch = pend_unch;
      end
      ev = act_unch | (act_en[s] & act_mask[s][7 - b]);
      ed = ev & din;
      @(posedge clk); #1;
      check(valid == ev, $sformatf("%s valid s%0d b%0d", tag, s, b), int'(valid), int'(ev));
      check(dout == ed, $sformatf("%s/R8 data s%0d b%0d", tag, s, b), int'(dout), int'(ed));
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    end
    @(negedge clk); bit_en = 0; sync = 0;
  endtask

  task automatic t_reset;  // R1
    check(valid == 0 && dout == 0, "R1 outputs in reset", int'(valid), 0);
    rst_n = 1;
    run_frame(1, -1, '0, '0, "R1 unconfigured");
  endtask

  task automatic t_hyper;  // R4 R2 R11 slot encoding
    cfg_write(AW'(1), 9'h1FF);
    cfg_write(AW'(2), 9'h1FF);
    cfg_write(AW'(SLOTS - 1), 9'h1FF);
    run_frame(1, -1, '0, '0, "R4/R2");
  endtask

  task automatic t_sub;  // R5 R6
    cfg_write(AW'(1), 9'h000);
    cfg_write(AW'(2), 9'h000);
    cfg_write(AW'(SLOTS - 1), 9'h000);
    cfg_write(AW'(5), 9'h1FE);  // 56 kbit/s
    cfg_write(AW'(9), 9'h181);
    cfg_write(AW'(7), 9'h0FF);  // mask set but slot disabled
    run_frame(1, -1, '0, '0, "R5/R6");
  endtask

  task automatic t_cfg_timing;  // R10 R9
    run_frame(1, 60, AW'(12), 9'h1F0, "R10 old map mid-frame");
    run_frame(1, 200, AW'(5), 9'h000, "R10 new map at sync");
    run_frame(1, -1, '0, '0, "R10 second write applied");
  endtask

  task automatic t_wrap;  // R3
    run_frame(0, -1, '0, '0, "R3 wrap no sync");
    run_frame(0, -1, '0, '0, "R3 wrap again");
  endtask

  task automatic t_unch;  // R7 R11 mode encoding
    cfg_write(AW'(1) << (AW - 1), 9'h001);
    run_frame(1, -1, '0, '0, "R7/R11 unchannelized");
    cfg_write(AW'(1) << (AW - 1), 9'h000);
    run_frame(1, -1, '0, '0, "R11 back to channelized");
  endtask

  bit done = 0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < SLOTS; k++) begin
      pend_en[k] = 0; pend_mask[k] = 0; act_en[k] = 0; act_mask[k] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_hyper();
    t_sub();
    t_cfg_timing();
    t_wrap();
    t_unch();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule